// File: doc/BRIEF.md
# DRAM Channel Select Decoder

This block maps a system physical address onto one of two DRAM channels and forms the address relative to that channel. The caller presents an address together with a flag that says whether the address lies in the upper of the two channel-select ranges. It also supplies a set of configuration values: lock-step (ganged) operation, high-range enable and target channel, interleave enable and interleave address mode, three node-interleave enable bits, the memory-hole enable and offset, the high-range base offset, and the DRAM base address.

The channel is chosen by a fixed priority chain. Lock-step operation comes first. The high-range flag comes next. When interleaving is on, the channel is taken from one of several address bits, and in one mode from a low address bit XORed with the parity of five upper address bits. The channel address is the block-aligned system address minus an offset. That offset is the memory-hole offset, the high-range base offset or the DRAM base, depending on the range and the address.

A request is accepted on any rising edge where the request valid is high. The result appears with a response valid strobe on the next edge.

Top module: `dram_chan_sel`

## Requirements
- R1: When `cfg_ganged` is 1, the response channel is 0, whatever the other inputs are.
- R2: When not ganged and `hi_range_hit` is 1, the response channel equals `cfg_hi_chan`.
- R3: When not ganged, not in the high range, `cfg_intlv_en` is 1 and `cfg_intlv_mode` is 0, the channel is address bit 6.
- R4: In the same case with `cfg_intlv_mode[1]` set, the channel is the XOR of address bits 20 to 16, further XORed with address bit 9 when `cfg_intlv_mode[0]` is 1, or with address bit 6 when it is 0.
- R5: In the same case with `cfg_intlv_mode` equal to 1, the channel is address bit 15 if `cfg_node_intlv[2]` is set, else bit 14 if `cfg_node_intlv[1]` is set, else bit 13 if `cfg_node_intlv[0]` is set, else bit 12.
- R6: When not ganged, not in the high range and interleave is off, the channel is the inverse of `cfg_hi_chan` if `cfg_hi_en` is 1, and 0 otherwise.
- R7: The channel address equals the system address with bits 5:0 cleared, minus the selected offset with bits 22:0 cleared, modulo 2^48.
- R8: The selected offset is `cfg_hole_ofs` shifted left by 16 when `cfg_hole_en` is 1 and the address is at least 2^32. Otherwise it is `cfg_sel_base_ofs` when `hi_range_hit` is 1, or `cfg_dram_base` with bits 26:0 cleared when `hi_range_hit` is 0.
- R9: `rsp_valid` is high exactly in the cycle after a cycle in which `req_valid` was high. `rsp_chan` and `rsp_chan_addr` change only after an accepted request.
- R10: While `rst_n` is low on a rising edge, `rsp_valid` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| sys_addr | input | 48 | System physical address |
| hi_range_hit | input | 1 | Address lies in the high select range |
| cfg_ganged | input | 1 | Both channels run in lock-step |
| cfg_hi_en | input | 1 | High select range enabled |
| cfg_hi_chan | input | 1 | Channel that owns the high range |
| cfg_intlv_en | input | 1 | Channel interleave enabled |
| cfg_intlv_mode | input | 2 | Interleave address mode |
| cfg_node_intlv | input | 3 | Node interleave enable bits |
| cfg_hole_en | input | 1 | Memory hole remapping enabled |
| cfg_hole_ofs | input | 16 | Hole offset in 64 KiB units |
| cfg_sel_base_ofs | input | 48 | Offset for the high select range |
| cfg_dram_base | input | 48 | DRAM base address |
| rsp_valid | output | 1 | Response strobe |
| rsp_chan | output | 1 | Selected channel |
| rsp_chan_addr | output | 48 | Channel-relative address |

## Verification
The hard cases are the ones where several priority levels are enabled at once and only the highest must win. Examples are interleave on together with the high-range flag, or ganged mode together with every other enable. The offset choice also splits on the 4 GiB line while the hole is enabled. Random stimulus draws each enable bit independently, so all levels of the priority chain appear overlaid. Directed requests place addresses exactly at 2^32 and 2^32 - 64, and walk each node-interleave bit and each interleave mode separately.

// File: rtl/dram_chan_sel.sv
module dram_chan_sel #(
  parameter int ADDR_W     = 48,
  parameter int HOLE_W     = 16,
  parameter int HOLE_SH    = 16,
  parameter int BLK_BITS   = 6,
  parameter int OFS_LSB    = 23,
  parameter int BASE_LSB   = 27,
  parameter int FOUR_G_BIT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] sys_addr,
  input  logic              hi_range_hit,
  input  logic              cfg_ganged,
  input  logic              cfg_hi_en,
  input  logic              cfg_hi_chan,
  input  logic              cfg_intlv_en,
  input  logic [1:0]        cfg_intlv_mode,
  input  logic [2:0]        cfg_node_intlv,
  input  logic              cfg_hole_en,
  input  logic [HOLE_W-1:0] cfg_hole_ofs,
  input  logic [ADDR_W-1:0] cfg_sel_base_ofs,
  input  logic [ADDR_W-1:0] cfg_dram_base,
  output logic              rsp_valid,
  output logic              rsp_chan,
  output logic [ADDR_W-1:0] rsp_chan_addr
);
  localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] FOUR_G    = ONE << FOUR_G_BIT;
  localparam logic [ADDR_W-1:0] BLK_MASK  = ~((ONE << BLK_BITS) - ONE);
  localparam logic [ADDR_W-1:0] OFS_MASK  = ~((ONE << OFS_LSB) - ONE);
  localparam logic [ADDR_W-1:0] BASE_MASK = ~((ONE << BASE_LSB) - ONE);

  logic              hash_par;
  logic              intlv_bit;
  logic              chan_nxt;
  logic              above_4g;
  logic [ADDR_W-1:0] hole_ext;
  logic [ADDR_W-1:0] ofs_sel;
  logic [ADDR_W-1:0] addr_nxt;

  assign hash_par = ^sys_addr[20:16];
  assign above_4g = sys_addr >= FOUR_G;
  assign hole_ext = ADDR_W'(cfg_hole_ofs) << HOLE_SH;

  always_comb begin
    if (cfg_intlv_mode == 2'd0)       intlv_bit = sys_addr[6];
    else if (cfg_intlv_mode[1])       intlv_bit = hash_par ^ (cfg_intlv_mode[0] ? sys_addr[9] : sys_addr[6]);
    else if (cfg_node_intlv[2])       intlv_bit = sys_addr[15];
    else if (cfg_node_intlv[1])       intlv_bit = sys_addr[14];
    else if (cfg_node_intlv[0])       intlv_bit = sys_addr[13];
    else                              intlv_bit = sys_addr[12];
  end

  always_comb begin
    if (cfg_ganged)        chan_nxt = 1'b0;
    else if (hi_range_hit) chan_nxt = cfg_hi_chan;
    else if (cfg_intlv_en) chan_nxt = intlv_bit;
    else if (cfg_hi_en)    chan_nxt = ~cfg_hi_chan;
    else                   chan_nxt = 1'b0;
  end

  assign ofs_sel  = (cfg_hole_en && above_4g) ? hole_ext :
                    hi_range_hit              ? cfg_sel_base_ofs :
                                                (cfg_dram_base & BASE_MASK);
  assign addr_nxt = (sys_addr & BLK_MASK) - (ofs_sel & OFS_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= req_valid;
  end

  always_ff @(posedge clk) begin
    if (req_valid) begin
      rsp_chan      <= chan_nxt;
      rsp_chan_addr <= addr_nxt;
    end
  end
endmodule

// File: rtl/dram_chan_sel_chk.sv
module dram_chan_sel_chk #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              hi_range_hit,
  input logic              cfg_ganged,
  input logic              cfg_hi_chan,
  input logic              rsp_valid,
  input logic              rsp_chan,
  input logic [ADDR_W-1:0] rsp_chan_addr
);
  p_resp_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_chan) && $stable(rsp_chan_addr)));
  p_ganged_chan0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cfg_ganged) |=> !rsp_chan);
  p_hi_range_chan_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cfg_ganged && hi_range_hit) |=> (rsp_chan == $past(cfg_hi_chan)));
  p_block_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_chan_addr[5:0] == 6'd0));
  p_reset_clears_r10: assert property (@(posedge clk)
    !rst_n |=> !rsp_valid);
endmodule

bind dram_chan_sel dram_chan_sel_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .hi_range_hit(hi_range_hit),
  .cfg_ganged(cfg_ganged), .cfg_hi_chan(cfg_hi_chan), .rsp_valid(rsp_valid),
  .rsp_chan(rsp_chan), .rsp_chan_addr(rsp_chan_addr)
);

// File: tb/dram_chan_sel_bench.sv
`timescale 1ns/1ps
module dram_chan_sel_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic [47:0] sys_addr = '0;
  logic        hi_range_hit = 0, cfg_ganged = 0, cfg_hi_en = 0, cfg_hi_chan = 0;
  logic        cfg_intlv_en = 0, cfg_hole_en = 0;
  logic [1:0]  cfg_intlv_mode = '0;
  logic [2:0]  cfg_node_intlv = '0;
  logic [15:0] cfg_hole_ofs = '0;
  logic [47:0] cfg_sel_base_ofs = '0, cfg_dram_base = '0;
  logic        rsp_valid, rsp_chan;
  logic [47:0] rsp_chan_addr;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dram_chan_sel u_dram_chan_sel (.*);

  function automatic string chan_tag();
    if (cfg_ganged) return "R1";
    if (hi_range_hit) return "R2";
    if (cfg_intlv_en) begin
      if (cfg_intlv_mode == 2'd0) return "R3";
      if (cfg_intlv_mode[1]) return "R4";
      return "R5";
    end
    return "R6";
  endfunction

  function automatic logic exp_chan();
    logic p;
    if (cfg_ganged) return 1'b0;
    if (hi_range_hit) return cfg_hi_chan;
    if (cfg_intlv_en) begin
      p = sys_addr[16] ^ sys_addr[17] ^ sys_addr[18] ^ sys_addr[19] ^ sys_addr[20];
      case (cfg_intlv_mode)
        2'd0: return sys_addr[6];
        2'd2: return p ^ sys_addr[6];
        2'd3: return p ^ sys_addr[9];
        default: begin
          if (cfg_node_intlv[2]) return sys_addr[15];
          if (cfg_node_intlv[1]) return sys_addr[14];
          if (cfg_node_intlv[0]) return sys_addr[13];
          return sys_addr[12];
        end
      endcase
    end
    if (cfg_hi_en) return !cfg_hi_chan;
    return 1'b0;
  endfunction

  function automatic logic [47:0] exp_addr();
    logic [47:0] o;
    if (cfg_hole_en && sys_addr >= 48'h1_0000_0000) o = {16'h0, cfg_hole_ofs, 16'h0};
    else if (hi_range_hit) o = cfg_sel_base_ofs;
    else o = {cfg_dram_base[47:27], 27'h0};
    return {sys_addr[47:6], 6'h0} - {o[47:23], 23'h0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_req();
    logic        ec;
    logic [47:0] ea;
    string       t;
    req_valid = 1;
    ec = exp_chan(); ea = exp_addr(); t = chan_tag();
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid === 1'b1, "R9", 48'(rsp_valid), 48'd1);
    chk(rsp_chan === ec, t, 48'(rsp_chan), 48'(ec));
    chk(rsp_chan_addr === ea, (cfg_hole_en && sys_addr >= 48'h1_0000_0000) ? "R8" : "R7",
        rsp_chan_addr, ea);
  endtask

  task automatic rand_cfg();
    cfg_ganged       = ($urandom % 4) == 0;
    hi_range_hit     = $urandom % 2;
    cfg_hi_en        = $urandom % 2;
    cfg_hi_chan      = $urandom % 2;
    cfg_intlv_en     = $urandom % 2;
    cfg_intlv_mode   = 2'($urandom);
    cfg_node_intlv   = 3'($urandom);
    cfg_hole_en      = $urandom % 2;
    cfg_hole_ofs     = 16'($urandom);
    cfg_sel_base_ofs = {16'($urandom), 32'($urandom)};
    cfg_dram_base    = {16'($urandom), 32'($urandom)};
    sys_addr         = ($urandom % 2) ? {16'($urandom), 32'($urandom)} : {16'h0, 32'($urandom)};
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic        hc;
    logic [47:0] ha;
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk);
    req_valid = 1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R10", 48'(rsp_valid), 48'd0);
    req_valid = 0;
    rst_n = 1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R9", 48'(rsp_valid), 48'd0);

    // R1: ganged wins over everything
    cfg_ganged = 1; hi_range_hit = 1; cfg_hi_chan = 1; cfg_hi_en = 1; cfg_intlv_en = 1;
    sys_addr = 48'hFFFF_FFFF_FFC0;
    run_req();
    cfg_ganged = 0;
    // R2: high range over interleave
    sys_addr = 48'h40; cfg_hi_chan = 0; run_req();
    cfg_hi_chan = 1; run_req();
    hi_range_hit = 0;
    // R3
    cfg_intlv_mode = 0; sys_addr = 48'h40; run_req();
    sys_addr = 48'hFFFF_FFFF_FFBF; run_req();
    // R4
    cfg_intlv_mode = 2; sys_addr = 48'h1_0040; run_req();
    cfg_intlv_mode = 3; sys_addr = 48'h3_0200; run_req();
    sys_addr = 48'h1_0200; run_req();
    // R5: each node-interleave bit
    cfg_intlv_mode = 1;
    for (int k = 0; k < 8; k++) begin
      cfg_node_intlv = 3'(k);
      sys_addr = 48'h0000_0000_A000 ^ (48'(k) << 12);
      run_req();
    end
    // R6
    cfg_intlv_en = 0; cfg_hi_en = 1; cfg_hi_chan = 0; run_req();
    cfg_hi_en = 0; run_req();
    // R8: hole at the 4 GiB line
    cfg_hole_en = 1; cfg_hole_ofs = 16'h4000; cfg_dram_base = 48'h0;
    sys_addr = 48'h1_0000_0000; run_req();
    sys_addr = 48'h0_FFFF_FFC0; run_req();
    hi_range_hit = 1; cfg_sel_base_ofs = 48'h0_8080_0000; run_req();

    // R9: idle cycle with changed inputs leaves outputs alone
    hc = rsp_chan; ha = rsp_chan_addr;
    sys_addr = 48'h1234_5678_9AC0; cfg_hi_chan = ~cfg_hi_chan; hi_range_hit = 1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R9", 48'(rsp_valid), 48'd0);
    chk(rsp_chan === hc && rsp_chan_addr === ha, "R9", rsp_chan_addr, ha);

    for (int n = 0; n < 3000; n++) begin
      rand_cfg();
      run_req();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule